// File: doc/BRIEF.md
# Asynchronous External Bus Timing Engine

This block is the master side of an asynchronous, memory-mapped parallel bus. An internal requester presents one read or one write at a time. The engine turns it into a chip-select and strobe sequence on the external pins. Every access passes through three phases: setup (lead), strobe (active) and hold (trail). Reads and writes each have their own programmed phase lengths. A global doubling flag can stretch all three phases, and an optional ready input from the slave can extend the strobe phase.

Phase counts are kept in a timing clock that runs at half the system clock. The block provides this timing clock as a one-cycle enable and accepts requests only on that enable, so every phase lasts an exact, even number of system clocks. The block can also drive a bus clock pin at half the timing clock. Only the 16-bit bus width is served. While the width field holds any other code, requests are refused.

Top module: `async_bus_master`

## Requirements
- R1: An accepted access drives `bus_cs_n` low for lead, active and trail in that order. Exactly one strobe is low, and only during active: `bus_wr_n` for a write (`req_write`=1) and `bus_rd_n` for a read.
- R2: Lead, active and trail last 2*N system clocks, where N is the count for that phase. N comes from the read set or from the write set, depending on the access type.
- R3: A lead count of 0 behaves as 1, and an active count of 0 behaves as 1. A trail count of 0 gives no trail.
- R4: With `cfg_double`=1, the effective lead, active and trail counts are all twice their values, for both reads and writes.
- R5: With `cfg_use_ready`=1, `bus_ready` passes through a two-flop synchronizer. The active phase ends at the first timing edge at or after its nominal end at which the synchronized ready is high. The phase therefore grows in steps of 2 system clocks.
- R6: With `cfg_use_ready`=0, `bus_ready` has no effect on the active length.
- R7: During a write, `bus_doe` is high and `bus_dout` and `bus_addr` hold the request values from the first lead cycle through the last trail cycle. During a read, `bus_doe` stays low.
- R8: A read captures `bus_din` at the end of the active phase and returns it on `rdata`. Every access ends with `done` high for exactly one cycle, in the first cycle after `bus_cs_n` rises.
- R9: `busy` is high from acceptance until trail ends. A request is taken only while the engine is idle and the timing enable is set.
- R10: A request is accepted only when `cfg_size` is 2'b11 (16-bit). Any other code leaves the bus idle and `busy` low.
- R11: With `cfg_clk_en`=1, `bus_clk` toggles every 2 system clocks, giving a period of 4. With `cfg_clk_en`=0, it is held low.
- R12: After reset, `bus_cs_n`, `bus_rd_n` and `bus_wr_n` are high, and `busy`, `done`, `bus_doe` and `bus_clk` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rd_lead | input | CNT_W | Read lead count |
| cfg_rd_active | input | CNT_W | Read active count |
| cfg_rd_trail | input | CNT_W | Read trail count |
| cfg_wr_lead | input | CNT_W | Write lead count |
| cfg_wr_active | input | CNT_W | Write active count |
| cfg_wr_trail | input | CNT_W | Write trail count |
| cfg_double | input | 1 | Doubles all phase counts |
| cfg_use_ready | input | 1 | Lets the slave ready extend active |
| cfg_clk_en | input | 1 | Enables the bus clock output |
| cfg_size | input | 2 | Bus width code; 2'b11 = 16-bit |
| req_valid | input | 1 | Request present, held until busy rises |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle end-of-access pulse |
| rdata | output | DATA_W | Captured read data |
| bus_addr | output | ADDR_W | External address |
| bus_dout | output | DATA_W | External write data |
| bus_doe | output | 1 | Data output enable |
| bus_din | input | DATA_W | External read data |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_ready | input | 1 | Asynchronous slave ready |
| bus_clk | output | 1 | Bus clock at half the timing clock |

## Verification
Most internal faults surface at the ports within one access. A wrong phase counter or a wrong phase transition changes the number of cycles between the fall of chip select, the fall and rise of the strobe, and the rise of chip select. A slave model measures these intervals and compares them with 2*N for every access. A wrong ready path shows up at the strobe's rising edge: the strobe is released too early, before ready reaches the engine, or more than two cycles late. A lost write latch or a lost read capture shows up on `bus_dout` in the same strobe or hold cycle, or on `rdata` when `done` pulses.

// File: rtl/async_bus_master.sv
module async_bus_master #(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 16,
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cfg_rd_lead,
  input  logic [CNT_W-1:0]  cfg_rd_active,
  input  logic [CNT_W-1:0]  cfg_rd_trail,
  input  logic [CNT_W-1:0]  cfg_wr_lead,
  input  logic [CNT_W-1:0]  cfg_wr_active,
  input  logic [CNT_W-1:0]  cfg_wr_trail,
  input  logic              cfg_double,
  input  logic              cfg_use_ready,
  input  logic              cfg_clk_en,
  input  logic [1:0]        cfg_size,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_doe,
  input  logic [DATA_W-1:0] bus_din,
  output logic              bus_cs_n,
  output logic              bus_rd_n,
  output logic              bus_wr_n,
  input  logic              bus_ready,
  output logic              bus_clk
);
  localparam int         LEN_W    = CNT_W + 2;
  localparam logic [1:0] SIZE_X16 = 2'b11;

  typedef enum logic [1:0] {IDLE, LEAD, ACTV, TRAIL} phase_t;

  phase_t                   ph;
  logic                     tick;
  logic                     clk_q;
  logic [SYNC_STAGES-1:0]   rdy_sync;
  logic [LEN_W-1:0]         cnt;
  logic [LEN_W-1:0]         act_len_q;
  logic [LEN_W-1:0]         trl_len_q;
  logic                     wr_q;
  logic                     rdy_en_q;
  logic [ADDR_W-1:0]        addr_q;
  logic [DATA_W-1:0]        wdata_q;
  logic [DATA_W-1:0]        rdata_q;
  logic                     done_q;

  function automatic logic [LEN_W-1:0] stretch(input logic [CNT_W-1:0] raw,
                                               input logic floor1,
                                               input logic dbl);
    logic [LEN_W-1:0] v;
    v = LEN_W'(raw);
    if (floor1 && raw == '0) v = LEN_W'(1);
    return dbl ? (v << 1) : v;
  endfunction

  wire [CNT_W-1:0] lead_raw  = req_write ? cfg_wr_lead   : cfg_rd_lead;
  wire [CNT_W-1:0] act_raw   = req_write ? cfg_wr_active : cfg_rd_active;
  wire [CNT_W-1:0] trail_raw = req_write ? cfg_wr_trail  : cfg_rd_trail;

  wire accept   = req_valid && tick && (ph == IDLE) && (cfg_size == SIZE_X16);
  wire rdy_ok   = !rdy_en_q || rdy_sync[SYNC_STAGES-1];
  wire cnt_zero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick     <= 1'b0;
      clk_q    <= 1'b0;
      rdy_sync <= '0;
    end else begin
      tick     <= ~tick;
      rdy_sync <= {rdy_sync[SYNC_STAGES-2:0], bus_ready};
      if (!cfg_clk_en) clk_q <= 1'b0;
      else if (tick)   clk_q <= ~clk_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph        <= IDLE;
      cnt       <= '0;
      act_len_q <= '0;
      trl_len_q <= '0;
      wr_q      <= 1'b0;
      rdy_en_q  <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      rdata_q   <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (ph)
        IDLE: if (accept) begin
          ph        <= LEAD;
          cnt       <= stretch(lead_raw, 1'b1, cfg_double) - LEN_W'(1);
          act_len_q <= stretch(act_raw, 1'b1, cfg_double);
          trl_len_q <= stretch(trail_raw, 1'b0, cfg_double);
          wr_q      <= req_write;
          rdy_en_q  <= cfg_use_ready;
          addr_q    <= req_addr;
          wdata_q   <= req_wdata;
        end
        LEAD: if (tick) begin
          if (cnt_zero) begin
            ph  <= ACTV;
            cnt <= act_len_q - LEN_W'(1);
          end else begin
            cnt <= cnt - LEN_W'(1);
          end
        end
        ACTV: if (tick) begin
          if (!cnt_zero) begin
            cnt <= cnt - LEN_W'(1);
          end else if (rdy_ok) begin
            if (!wr_q) rdata_q <= bus_din;
            if (trl_len_q == '0) begin
              ph     <= IDLE;
              done_q <= 1'b1;
            end else begin
              ph  <= TRAIL;
              cnt <= trl_len_q - LEN_W'(1);
            end
          end
        end
        TRAIL: if (tick) begin
          if (cnt_zero) begin
            ph     <= IDLE;
            done_q <= 1'b1;
          end else begin
            cnt <= cnt - LEN_W'(1);
          end
        end
        default: ph <= IDLE;
      endcase
    end
  end

  assign busy     = (ph != IDLE);
  assign done     = done_q;
  assign rdata    = rdata_q;
  assign bus_addr = addr_q;
  assign bus_dout = wdata_q;
  assign bus_doe  = busy && wr_q;
  assign bus_cs_n = (ph == IDLE);
  assign bus_rd_n = !((ph == ACTV) && !wr_q);
  assign bus_wr_n = !((ph == ACTV) && wr_q);
  assign bus_clk  = clk_q;
endmodule

// File: rtl/async_bus_master_chk.sv
module async_bus_master_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [1:0]        cfg_size,
  input logic              cfg_clk_en,
  input logic              busy,
  input logic              done,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_dout,
  input logic              bus_cs_n,
  input logic              bus_rd_n,
  input logic              bus_wr_n,
  input logic              bus_clk
);
  a_r1_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n && !bus_wr_n));

  a_r1_strobe_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd_n || !bus_wr_n) |-> !bus_cs_n);

  a_r3_lead_first: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_cs_n) |-> (bus_rd_n && bus_wr_n));

  a_r3_lead_second: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_cs_n) |=> (!bus_cs_n && bus_rd_n && bus_wr_n));

  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_cs_n && !$past(bus_cs_n)) |-> ($stable(bus_dout) && $stable(bus_addr)));

  a_r8_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($rose(bus_cs_n) && !busy));

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_size_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && cfg_size != 2'b11) |=> !busy);

  a_r11_clk_off: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_clk_en |=> !bus_clk);
endmodule

bind async_bus_master async_bus_master_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/async_bus_master_test.sv
module async_bus_master_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cfg_rd_lead = 4'd1, cfg_rd_active = 4'd1, cfg_rd_trail = 4'd1;
  logic [3:0]  cfg_wr_lead = 4'd1, cfg_wr_active = 4'd1, cfg_wr_trail = 4'd1;
  logic        cfg_double = 1'b0, cfg_use_ready = 1'b0, cfg_clk_en = 1'b1;
  logic [1:0]  cfg_size = 2'b11;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic        busy, done, bus_doe, bus_cs_n, bus_rd_n, bus_wr_n, bus_clk;
  logic [15:0] rdata, bus_addr, bus_dout;
  logic [15:0] bus_din = '0;
  logic        bus_ready = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  async_bus_master uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_rd_lead(cfg_rd_lead), .cfg_rd_active(cfg_rd_active), .cfg_rd_trail(cfg_rd_trail),
    .cfg_wr_lead(cfg_wr_lead), .cfg_wr_active(cfg_wr_active), .cfg_wr_trail(cfg_wr_trail),
    .cfg_double(cfg_double), .cfg_use_ready(cfg_use_ready), .cfg_clk_en(cfg_clk_en),
    .cfg_size(cfg_size), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done), .rdata(rdata),
    .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din),
    .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .bus_ready(bus_ready), .bus_clk(bus_clk)
  );

  typedef struct packed {
    logic        wr;
    logic [3:0]  lead;
    logic [3:0]  act;
    logic [3:0]  trail;
    logic        dbl;
    logic        rdy;
    logic [7:0]  rdy_at;
    logic [15:0] addr;
    logic [15:0] data;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 4'd3, 4'd7, 4'd3, 1'b1, 1'b1, 8'd4,  16'h0100, 16'h0009},
    '{1'b0, 4'd3, 4'd7, 4'd3, 1'b1, 1'b1, 8'd32, 16'h0104, 16'hC3A5},
    '{1'b1, 4'd1, 4'd2, 4'd0, 1'b0, 1'b0, 8'd0,  16'h0200, 16'h1234},
    '{1'b0, 4'd2, 4'd1, 4'd1, 1'b0, 1'b1, 8'd7,  16'h0208, 16'h8001},
    '{1'b0, 4'd0, 4'd0, 4'd2, 1'b0, 1'b0, 8'd0,  16'h0300, 16'h7E7E},
    '{1'b1, 4'd4, 4'd3, 4'd1, 1'b1, 1'b0, 8'd0,  16'h0304, 16'hFFFF}
  };

  task automatic chk(input bit ok, input string req, input int actual, input int expected);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  function automatic int nominal(input logic [3:0] raw, input logic floor1, input logic dbl);
    int n;
    n = (floor1 && raw == 0) ? 1 : int'(raw);
    return 2 * n * (dbl ? 2 : 1);
  endfunction

  task automatic run_vec(input vec_t v);
    int lead_c = 0, act_c = 0, trl_c = 0, guard = 0;
    int e_lead, e_act, e_trl, need;
    bit seen_act = 0, bad_data = 0, bad_kind = 0, bad_busy = 0;
    bit s_low, o_low;
    e_lead = nominal(v.lead, 1'b1, v.dbl);
    e_act  = nominal(v.act, 1'b1, v.dbl);
    e_trl  = nominal(v.trail, 1'b0, v.dbl);
    need   = int'(v.rdy_at) + 2;
    if (v.rdy && need > e_act) e_act = e_act + 2 * ((need - e_act + 1) / 2);

    @(negedge clk);
    bus_ready     = 1'b0;
    cfg_double    = v.dbl;
    cfg_use_ready = v.rdy;
    if (v.wr) begin
      cfg_wr_lead = v.lead; cfg_wr_active = v.act; cfg_wr_trail = v.trail;
      cfg_rd_lead = 4'd9;   cfg_rd_active = 4'd9;  cfg_rd_trail = 4'd9;
    end else begin
      cfg_rd_lead = v.lead; cfg_rd_active = v.act; cfg_rd_trail = v.trail;
      cfg_wr_lead = 4'd9;   cfg_wr_active = 4'd9;  cfg_wr_trail = 4'd9;
    end
    bus_din   = v.wr ? 16'h5A5A : v.data;
    req_write = v.wr;
    req_addr  = v.addr;
    req_wdata = v.wr ? v.data : 16'hFFFF;
    req_valid = 1'b1;
    while (!busy && guard < 8) begin
      @(negedge clk);
      guard++;
    end
    req_valid = 1'b0;
    chk(busy, "R9 accept", int'(busy), 1);
    guard = 0;
    while (!bus_cs_n && guard < 400) begin
      s_low = v.wr ? !bus_wr_n : !bus_rd_n;
      o_low = v.wr ? !bus_rd_n : !bus_wr_n;
      if (o_low) bad_kind = 1;
      if (!busy) bad_busy = 1;
      if (s_low) begin
        act_c++;
        if (seen_act && act_c > 1 && lead_c == 0) bad_kind = 1;
        seen_act = 1;
        if (trl_c != 0) bad_kind = 1;
        if (v.rdy && act_c == int'(v.rdy_at)) bus_ready = 1'b1;
      end else if (!seen_act) lead_c++;
      else trl_c++;
      if (v.wr) begin
        if (!bus_doe || bus_dout != v.data) bad_data = 1;
      end else if (bus_doe) bad_data = 1;
      if (bus_addr != v.addr) bad_data = 1;
      guard++;
      @(negedge clk);
    end
    chk(lead_c == e_lead, "R2/R3/R4 lead length", lead_c, e_lead);
    chk(act_c == e_act, "R2/R4/R5/R6 active length", act_c, e_act);
    chk(trl_c == e_trl, "R2/R4 trail length", trl_c, e_trl);
    chk(!bad_kind, "R1 phase order and strobe type", int'(bad_kind), 0);
    chk(!bad_data, "R7 data and address hold", int'(bad_data), 0);
    chk(!bad_busy, "R9 busy through access", int'(bad_busy), 0);
    chk(done && !busy, "R8 done at end", int'(done), 1);
    if (!v.wr) chk(rdata == v.data, "R8 read capture", int'(rdata), int'(v.data));
    bus_din   = ~v.data;
    bus_ready = 1'b0;
    @(negedge clk);
    chk(!done, "R8 done one cycle", int'(done), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(bus_cs_n && bus_rd_n && bus_wr_n, "R12 strobes idle",
        int'({bus_cs_n, bus_rd_n, bus_wr_n}), 7);
    chk(!busy && !done && !bus_doe, "R12 status low", int'({busy, done, bus_doe}), 0);

    for (int i = 0; i < NV; i++) begin
      run_vec(VECS[i]);
      repeat (3) @(negedge clk);
    end

    // R10 unsupported width code refused
    begin
      bit seen = 0;
      cfg_size  = 2'b10;
      req_valid = 1'b1;
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        if (busy || !bus_cs_n) seen = 1;
      end
      chk(!seen, "R10 non-16-bit refused", int'(seen), 0);
      req_valid = 1'b0;
      cfg_size  = 2'b11;
      @(negedge clk);
    end

    // R11 bus clock output
    begin
      logic s [16];
      int changes = 0;
      bit bad = 0;
      cfg_clk_en = 1'b1;
      repeat (2) @(negedge clk);
      for (int k = 0; k < 16; k++) begin
        s[k] = bus_clk;
        @(negedge clk);
      end
      for (int k = 1; k < 16; k++) if (s[k] != s[k-1]) changes++;
      for (int k = 0; k < 14; k++) if (s[k] == s[k+2]) bad = 1;
      chk(changes >= 7 && changes <= 8 && !bad, "R11 bus clock period 4", changes, 8);
      cfg_clk_en = 1'b0;
      @(negedge clk);
      bad = 0;
      for (int k = 0; k < 8; k++) begin
        if (bus_clk) bad = 1;
        @(negedge clk);
      end
      chk(!bad, "R11 bus clock held low", int'(bad), 0);
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule